// File: doc/BRIEF.md
# Serial Supervisor Register Command Decoder

This block sits behind a byte-level two-wire bus front end inside a supply supervisor. The front end reports START and STOP conditions and hands over each received byte with a strobe. The block answers every byte with an acknowledge decision on the next cycle. It decodes two kinds of write frame. Control-register writes update a shadow copy of the nonvolatile watchdog, power-on-delay and protection settings. Threshold commands raise a one-cycle pulse that sets or clears one of the two trip thresholds.

Control-register stores are gated by two volatile enable latches, which software arms in two separate frames before the store frame. Threshold commands are accepted only if the high-voltage qualifier was present at START. Nothing is committed before the STOP that closes a complete frame. Each committed store or threshold command starts a busy window that models the nonvolatile write time. During that window every byte is refused.

Top module: `sreg_cmd_decoder`

## Requirements
- R1: After reset, `ack_o`, `busy_o`, `wel_o`, `rwel_o` and all threshold pulses are 0, and `tx_data_o` equals the `NV_INIT` parameter.
- R2: `ack_o` is high in the cycle after a byte strobe only when that byte is accepted. Accepted bytes are: slave byte B2h (control write) or B3h (control read) as the first byte after START, then in a control write the address FFh and the first data byte. Any other slave byte is refused, and all bytes after a refused byte in that frame are refused too.
- R3: In a control write, bytes after the first data byte are refused and have no effect on what is committed.
- R4: A control write with data 02h sets the write latch at STOP. Data 06h sets the register latch at STOP only if the write latch is already set; otherwise nothing changes. Neither frame starts the busy window.
- R5: Any other control write data byte is stored at STOP only if both latches are set. The fields are: watchdog select in bits 7:6, power-on delay in bits 5:4, protection in bits 3 and 0. Both latches are cleared by the store. If a latch is missing, the byte is still acknowledged but ignored.
- R6: Writes take effect only on a STOP. A new START before the STOP discards the pending frame.
- R7: If the qualifier `hv_en_i` is high at START, the frame A0h, address, 00h, STOP gives a one-cycle pulse after the STOP. Address 01h pulses `thr_set_o[0]`, 09h pulses `thr_set_o[1]`, 03h pulses `thr_clr_o[0]` and 0Bh pulses `thr_clr_o[1]`. Address bit 3 selects the threshold and bit 1 selects clear. The qualifier is sampled only at START.
- R8: If the qualifier is low at START, slave A0h is refused. An address outside the four codes, or a data byte other than 00h, is refused. No threshold pulse follows any of these frames.
- R9: A committed store or threshold command raises `busy_o` in the cycle after the STOP for exactly `BUSY_CYCLES` cycles. While it is high, every byte is refused and no frame commits.
- R10: `tx_data_o` always shows the register image: the R5 fields, with the write latch in bit 1 and the register latch in bit 2. This image is the byte a control read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | START or repeated START seen, one-cycle strobe |
| stop_i | input | 1 | STOP seen, one-cycle strobe |
| rx_valid_i | input | 1 | Received-byte strobe |
| rx_byte_i | input | 8 | Received byte |
| hv_en_i | input | 1 | High-voltage programming qualifier |
| ack_o | output | 1 | Acknowledge decision for the previous cycle's byte |
| tx_data_o | output | 8 | Register image for reads |
| wd_sel_o | output | 2 | Watchdog interval select |
| por_sel_o | output | 2 | Power-on reset delay select |
| prot_o | output | 2 | Block protection select |
| wel_o | output | 1 | Write enable latch |
| rwel_o | output | 1 | Register write enable latch |
| thr_set_o | output | 2 | Threshold set pulses, one per threshold |
| thr_clr_o | output | 2 | Threshold clear pulses, one per threshold |
| busy_o | output | 1 | Nonvolatile write in progress |

## Verification
The assertions assume the front end never gives START, STOP and a byte strobe in the same cycle, and that every strobe lasts one cycle. The bench drives each of these events alone, at a falling edge, for exactly one cycle. It keeps an idle cycle between events. The assertions also assume that bytes only arrive between a START and a STOP. The bench sends every byte inside a frame, and it sends frames during the busy window only to test that they are refused.

// File: rtl/sreg_dec_pkg.sv
package sreg_dec_pkg;
  localparam int          BYTE_W      = 8;
  localparam int          NUM_THR     = 2;
  localparam int          B_WEL       = 1;
  localparam int          B_RWEL      = 2;
  localparam logic [7:0]  CTRL_SLV_WR = 8'hB2;
  localparam logic [7:0]  CTRL_SLV_RD = 8'hB3;
  localparam logic [7:0]  THR_SLV     = 8'hA0;
  localparam logic [7:0]  CTRL_ADR    = 8'hFF;
  localparam logic [7:0]  CODE_WEL    = 8'h02;
  localparam logic [7:0]  CODE_RWEL   = 8'h06;
  localparam logic [7:0]  LATCH_MASK  = 8'h06;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SLAVE, PH_ADDR, PH_DATA, PH_EXTRA, PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {FK_NONE, FK_CTRL, FK_THR} frame_t;

  function automatic logic thr_addr_ok(input logic [7:0] a);
    return (a == 8'h01) || (a == 8'h09) || (a == 8'h03) || (a == 8'h0B);
  endfunction
endpackage

// File: rtl/sreg_frame_dec.sv
module sreg_frame_dec
  import sreg_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              hv_en_i,
  input  logic              busy_i,
  output logic              ack_o,
  output logic              armed_o,
  output frame_t            kind_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              thr_hi_o,
  output logic              thr_clr_o
);
  phase_t phase_q;
  logic   hv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      kind_o    <= FK_NONE;
      hv_q      <= 1'b0;
      armed_o   <= 1'b0;
      ack_o     <= 1'b0;
      data_o    <= '0;
      thr_hi_o  <= 1'b0;
      thr_clr_o <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_SLAVE;
        kind_o  <= FK_NONE;
        hv_q    <= hv_en_i;
        armed_o <= 1'b0;
      end else if (stop_i) begin
        phase_q <= PH_IDLE;
        kind_o  <= FK_NONE;
        armed_o <= 1'b0;
      end else if (rx_valid_i) begin
        case (phase_q)
          PH_SLAVE: begin
            if (busy_i) begin
              phase_q <= PH_SKIP;
            end else if (rx_byte_i == CTRL_SLV_WR) begin
              kind_o  <= FK_CTRL;
              phase_q <= PH_ADDR;
              ack_o   <= 1'b1;
            end else if (rx_byte_i == CTRL_SLV_RD) begin
              phase_q <= PH_SKIP;
              ack_o   <= 1'b1;
            end else if (rx_byte_i == THR_SLV && hv_q) begin
              kind_o  <= FK_THR;
              phase_q <= PH_ADDR;
              ack_o   <= 1'b1;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            if (kind_o == FK_CTRL && rx_byte_i == CTRL_ADR) begin
              phase_q <= PH_DATA;
              ack_o   <= 1'b1;
            end else if (kind_o == FK_THR && thr_addr_ok(rx_byte_i)) begin
              thr_hi_o  <= rx_byte_i[3];
              thr_clr_o <= rx_byte_i[1];
              phase_q   <= PH_DATA;
              ack_o     <= 1'b1;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          PH_DATA: begin
            if (kind_o == FK_CTRL) begin
              data_o  <= rx_byte_i;
              armed_o <= 1'b1;
              phase_q <= PH_EXTRA;
              ack_o   <= 1'b1;
            end else if (rx_byte_i == '0) begin
              armed_o <= 1'b1;
              phase_q <= PH_EXTRA;
              ack_o   <= 1'b1;
            end else begin
              phase_q <= PH_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(rx_valid_i)); // R2
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (rst)
    (busy_i && rx_valid_i) |=> !ack_o); // R9
  AST_ARMED_HAS_KIND: assert property (@(posedge clk) disable iff (rst)
    armed_o |-> (kind_o != FK_NONE)); // R6
endmodule

// File: rtl/sreg_commit.sv
module sreg_commit
  import sreg_dec_pkg::*;
#(
  parameter logic [7:0] NV_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_i,
  input  logic              armed_i,
  input  frame_t            kind_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              thr_hi_i,
  input  logic              thr_clr_i,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [NUM_THR-1:0] thr_set_o,
  output logic [NUM_THR-1:0] thr_clr_o,
  output logic              store_o
);
  logic do_commit;
  logic is_latch_op;

  assign do_commit   = stop_i && armed_i;
  assign is_latch_op = (data_i == CODE_WEL) || (data_i == CODE_RWEL);

  always_comb begin
    store_o = 1'b0;
    if (do_commit) begin
      if (kind_i == FK_THR)
        store_o = 1'b1;
      else if (kind_i == FK_CTRL && !is_latch_op && ctrl_q[B_WEL] && ctrl_q[B_RWEL])
        store_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= NV_INIT & ~LATCH_MASK;
    end else if (do_commit && kind_i == FK_CTRL) begin
      if (data_i == CODE_WEL) begin
        ctrl_q[B_WEL] <= 1'b1;
      end else if (data_i == CODE_RWEL) begin
        if (ctrl_q[B_WEL]) ctrl_q[B_RWEL] <= 1'b1;
      end else if (ctrl_q[B_WEL] && ctrl_q[B_RWEL]) begin
        ctrl_q <= data_i & ~LATCH_MASK;
      end
    end
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    logic set_q, clr_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        set_q <= 1'b0;
        clr_q <= 1'b0;
      end else begin
        set_q <= do_commit && kind_i == FK_THR && !thr_clr_i && (thr_hi_i == 1'(g));
        clr_q <= do_commit && kind_i == FK_THR &&  thr_clr_i && (thr_hi_i == 1'(g));
      end
    end
    assign thr_set_o[g] = set_q;
    assign thr_clr_o[g] = clr_q;
  end

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[B_RWEL] |-> ctrl_q[B_WEL]); // R4
  AST_NV_HOLD_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    !stop_i |=> $stable({ctrl_q[7:3], ctrl_q[0]})); // R6
  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({thr_set_o, thr_clr_o})); // R7
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (|{thr_set_o, thr_clr_o}) |=> !(|{thr_set_o, thr_clr_o})); // R7
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (store_o && kind_i == FK_CTRL) |=> (ctrl_q[B_WEL] == 1'b0 && ctrl_q[B_RWEL] == 1'b0)); // R5
endmodule

// File: rtl/sreg_busy_timer.sv
module sreg_busy_timer #(
  parameter int BUSY_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(BUSY_CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_o); // R9
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cnt_q == '0)); // R9
endmodule

// File: rtl/sreg_cmd_decoder.sv
module sreg_cmd_decoder
  import sreg_dec_pkg::*;
#(
  parameter int         BUSY_CYCLES = 1_000_000,
  parameter logic [7:0] NV_INIT     = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       hv_en_i,
  output logic       ack_o,
  output logic [7:0] tx_data_o,
  output logic [1:0] wd_sel_o,
  output logic [1:0] por_sel_o,
  output logic [1:0] prot_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic [1:0] thr_set_o,
  output logic [1:0] thr_clr_o,
  output logic       busy_o
);
  logic              armed;
  frame_t            kind;
  logic [BYTE_W-1:0] data;
  logic              thr_hi, thr_clr_sel, store;
  logic [BYTE_W-1:0] ctrl;

  sreg_frame_dec u_dec (
    .clk, .rst, .start_i, .stop_i, .rx_valid_i, .rx_byte_i, .hv_en_i,
    .busy_i(busy_o), .ack_o, .armed_o(armed), .kind_o(kind), .data_o(data),
    .thr_hi_o(thr_hi), .thr_clr_o(thr_clr_sel)
  );

  sreg_commit #(.NV_INIT(NV_INIT)) u_commit (
    .clk, .rst, .stop_i, .armed_i(armed), .kind_i(kind), .data_i(data),
    .thr_hi_i(thr_hi), .thr_clr_i(thr_clr_sel), .ctrl_q(ctrl),
    .thr_set_o, .thr_clr_o, .store_o(store)
  );

  sreg_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk, .rst, .start_i(store), .busy_o
  );

  assign tx_data_o = ctrl;
  assign wd_sel_o  = ctrl[7:6];
  assign por_sel_o = ctrl[5:4];
  assign prot_o    = {ctrl[3], ctrl[0]};
  assign wel_o     = ctrl[B_WEL];
  assign rwel_o    = ctrl[B_RWEL];
endmodule

// File: tb/sreg_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module sreg_cmd_decoder_tb_top;
  localparam int         BUSY = 20;
  localparam logic [7:0] INIT = 8'h41;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, hv_en_i = 0;
  logic [7:0] rx_byte_i = 0;
  logic ack_o, wel_o, rwel_o, busy_o;
  logic [7:0] tx_data_o;
  logic [1:0] wd_sel_o, por_sel_o, prot_o, thr_set_o, thr_clr_o;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_q[$];
  logic seen_q = 1'b0;

  always #2.5 clk = ~clk;

  sreg_cmd_decoder #(.BUSY_CYCLES(BUSY), .NV_INIT(INIT)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected acknowledge for each strobed byte
  always @(posedge clk) seen_q <= rx_valid_i;
  always @(negedge clk) begin
    if (!rst && seen_q) begin
      if (exp_q.size() == 0) chk("R2 ack without expectation", 1, 0);
      else chk("R2 ack", {31'd0, ack_o}, {31'd0, exp_q.pop_front()});
    end
  end

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask
  task automatic do_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask
  task automatic send(input logic [7:0] b, input bit e);
    exp_q.push_back(e);
    @(negedge clk) begin rx_valid_i = 1; rx_byte_i = b; end
    @(negedge clk) rx_valid_i = 0;
  endtask
  task automatic ctrl_wr(input logic [7:0] d);
    do_start(); send(8'hB2, 1); send(8'hFF, 1); send(d, 1); do_stop();
  endtask
  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ack", ack_o, 0);          chk("R1 busy", busy_o, 0);
    chk("R1 wel", wel_o, 0);          chk("R1 rwel", rwel_o, 0);
    chk("R1 tx", tx_data_o, INIT);    chk("R1 pulses", {thr_clr_o, thr_set_o}, 0);

    ctrl_wr(8'hA8);
    chk("R5 store without latches ignored", tx_data_o, INIT);
    chk("R5 no busy when ignored", busy_o, 0);

    ctrl_wr(8'h06);
    chk("R4 rwel needs wel", rwel_o, 0);

    do_start(); send(8'hB2, 1); send(8'hFF, 1); send(8'h02, 1);
    chk("R6 wel before stop", wel_o, 0);
    do_stop();
    chk("R4 wel set", wel_o, 1);
    chk("R4 latch op no busy", busy_o, 0);

    ctrl_wr(8'h06);
    chk("R4 rwel set", rwel_o, 1);
    chk("R10 image with latches", tx_data_o, 8'h47);

    do_start(); send(8'hB2, 1); send(8'hFF, 1); send(8'hB9, 1); send(8'h00, 0);
    chk("R6 no store before stop", tx_data_o, 8'h47);
    do_stop();
    chk("R5 image after store", tx_data_o, 8'hB9);
    chk("R5 wd field", wd_sel_o, 2'b10);
    chk("R5 por field", por_sel_o, 2'b11);
    chk("R5 prot field", prot_o, 2'b11);
    chk("R5 latches cleared", {rwel_o, wel_o}, 0);
    begin
      int n = 0;
      while (busy_o && n < 1000) begin n++; @(negedge clk); end
      chk("R9 busy length", n, BUSY);
    end

    do_start(); send(8'hB3, 1); do_stop();
    chk("R10 read image", tx_data_o, 8'hB9);
    do_start(); send(8'h50, 0); send(8'hFF, 0); do_stop();

    do_start(); send(8'hB2, 1); send(8'hFF, 1); send(8'h02, 1);
    do_start(); send(8'hB3, 1); do_stop();
    chk("R6 repeated start discards", wel_o, 0);

    do_start(); send(8'hB2, 1); send(8'hFE, 0); send(8'h02, 0); do_stop();
    chk("R2 wrong address refused", wel_o, 0);

    do_start(); send(8'hA0, 0); send(8'h01, 0); send(8'h00, 0); do_stop();
    chk("R8 no qualifier no pulse", {thr_clr_o, thr_set_o}, 0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      logic [3:0] ep;
      case (i)
        0: begin a = 8'h01; ep = 4'b0001; end
        1: begin a = 8'h09; ep = 4'b0010; end
        2: begin a = 8'h03; ep = 4'b0100; end
        default: begin a = 8'h0B; ep = 4'b1000; end
      endcase
      @(negedge clk) hv_en_i = 1;
      do_start();
      hv_en_i = (i != 3);
      send(8'hA0, 1); send(a, 1); send(8'h00, 1); do_stop();
      chk("R7 threshold pulse", {thr_clr_o, thr_set_o}, ep);
      chk("R9 busy after threshold", busy_o, 1);
      @(negedge clk);
      chk("R7 pulse one cycle", {thr_clr_o, thr_set_o}, 0);
      if (i == 0) begin
        do_start(); send(8'hB2, 0); send(8'hFF, 0); send(8'h02, 0); do_stop();
        chk("R9 frame during busy ignored", wel_o, 0);
        chk("R9 still busy", busy_o, 1);
      end
      wait_idle();
    end

    @(negedge clk) hv_en_i = 1;
    do_start(); send(8'hA0, 1); send(8'h05, 0); send(8'h00, 0); do_stop();
    chk("R8 bad address no pulse", {thr_clr_o, thr_set_o}, 0);
    do_start(); send(8'hA0, 1); send(8'h01, 1); send(8'h01, 0); do_stop();
    chk("R8 bad data no pulse", {thr_clr_o, thr_set_o}, 0);
    chk("R8 no busy", busy_o, 0);
    hv_en_i = 0;

    do_start(); send(8'hB2, 1); send(8'hFF, 1); send(8'h02, 1); send(8'h06, 0); do_stop();
    chk("R3 extra byte ignored", {rwel_o, wel_o}, 2'b01);

    repeat (2) @(negedge clk);
    chk("R2 all acks consumed", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule